// File: doc/BRIEF.md
# Two-Pin Probe Serializer

This block lets an oscilloscope look at a wide internal register through just two chip pins. A 30-bit parallel word is captured into a holding register and sent out one bit per bit tick on a serial data pin. A companion marker pin is high only while the first bit of a frame is on the data pin, so it can serve as the scope's trigger source. Each frame has 32 slots. The 30 payload bits fill slots 0 to 29, with bit 0 first. Slots 30 and 31 are a quiet gap in which both pins stay low.

The block runs entirely on the system clock. A one-cycle bit-tick enable, typically produced elsewhere by dividing the system clock down to about 1 MHz, moves the slot counter forward, so the block never needs a derived clock. A mode input selects one of two behaviours. In free-run mode frames repeat back to back with no gap between them. In single-shot mode one frame is sent per update strobe, and a strobe that arrives while a frame is in flight is remembered and starts the next frame as soon as the current one ends.

Top module: `probe_serializer`

## Requirements
- R1: While the synchronous reset is high, and on the clock edge that samples it, the slot counter clears and both output pins go low. This also applies when reset arrives in the middle of a frame. After reset, single-shot mode stays idle until a strobe arrives.
- R2: With `one_shot` = 0, the first bit tick after reset starts a frame. Every bit tick after that either advances the slot or, after slot 31, starts a new frame at slot 0 with no idle slot in between.
- R3: In slot k, for k from 0 to 29, `probe_data` equals bit k of the word captured for that frame, so bit 0 is sent first.
- R4: In slots 30 and 31, both `probe_data` and `probe_mark` are low.
- R5: `probe_mark` is high exactly during slot 0 of every frame and low at all other times.
- R6: The slot advances only on clock edges where `bit_tick` is high. Without a tick, both outputs hold their values, whatever `word_upd` does.
- R7: The word is captured from `word_in` on the tick that starts a frame. Changes to `word_in` later in the frame do not change the bits sent in that frame.
- R8: With `one_shot` = 1, the block is idle with both pins low until a `word_upd` strobe. The next bit tick then starts one frame. After slot 31 the block returns to idle unless another strobe is pending.
- R9: With `one_shot` = 1, a strobe that arrives during a frame is held as pending. The tick after slot 31 then starts the next frame directly, capturing the value `word_in` has at that tick.
- R10: With `one_shot` = 1, several strobes during one frame produce only one follow-on frame, after which the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle enable that moves the frame forward by one slot |
| one_shot | input | 1 | Mode select: 0 = free-run, 1 = one frame per update strobe |
| word_in | input | 30 | Parallel word to observe |
| word_upd | input | 1 | One-cycle strobe that marks an update of `word_in` (used in single-shot mode) |
| probe_data | output | 1 | Serial data pin |
| probe_mark | output | 1 | Trigger marker, high during slot 0 of each frame |

## Verification
The bench walks every slot of several frames using varied bit patterns and varied gaps between ticks. It targets four kinds of fault:
- A counter that drifts by one slot would put each bit one position off, or move the marker out of slot 0.
- Gap slots that leak a payload bit would drive `probe_data` high in slot 30 or 31.
- Capturing the word continuously, instead of once per frame, would mix bits from two values inside a single frame. The bench changes `word_in` in mid-frame to expose this.
- In single-shot mode, a lost pending strobe would leave the line idle when a frame is due, and a pending flag that is never cleared would send frames without end. A mid-frame reset must also silence both pins at once.

// File: rtl/probe_ser_pkg.sv
package probe_ser_pkg;

  localparam int unsigned PROBE_WORD_W = 30;
  localparam int unsigned PROBE_SLOTS  = 32;

  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_SHOT = 1'b1
  } probe_mode_e;

  // true on the final slot of a frame
  function automatic logic slot_is_last(input int unsigned s, input int unsigned slots);
    return s == slots - 1;
  endfunction

  // true while the slot carries a payload bit rather than a gap
  function automatic logic slot_has_bit(input int unsigned s, input int unsigned word_w);
    return s < word_w;
  endfunction

  // slot that follows s inside a frame
  function automatic int unsigned slot_step(input int unsigned s);
    return s + 1;
  endfunction

endpackage

// File: rtl/probe_frame_ctrl.sv
module probe_frame_ctrl
  import probe_ser_pkg::*;
#(
  parameter int unsigned SLOTS = PROBE_SLOTS,
  localparam int unsigned CNT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  probe_mode_e      mode,
  input  logic             word_upd,
  output logic             frame_on,
  output logic [CNT_W-1:0] slot,
  output logic             frame_start,
  output logic             pend
);

  logic want_frame;
  logic at_boundary;
  logic frame_end;

  always_comb begin
    want_frame  = (mode == MODE_FREE) ? 1'b1 : (pend | word_upd);
    at_boundary = !frame_on || slot_is_last(32'(slot), SLOTS);
    frame_start = bit_tick && at_boundary && want_frame;
    frame_end   = bit_tick && frame_on && slot_is_last(32'(slot), SLOTS) && !want_frame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_on <= 1'b0;
      slot     <= '0;
    end else if (frame_start) begin
      frame_on <= 1'b1;
      slot     <= '0;
    end else if (frame_end) begin
      frame_on <= 1'b0;
      slot     <= '0;
    end else if (bit_tick && frame_on) begin
      slot <= CNT_W'(slot_step(32'(slot)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode == MODE_FREE || frame_start) begin
      pend <= 1'b0;
    end else if (word_upd) begin
      pend <= 1'b1;
    end
  end

endmodule

// File: rtl/probe_word_latch.sv
module probe_word_latch
  import probe_ser_pkg::*;
#(
  parameter int unsigned WORD_W = PROBE_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] shadow
);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (capture) begin
      shadow <= word_in;
    end
  end

endmodule

// File: rtl/probe_bit_select.sv
module probe_bit_select
  import probe_ser_pkg::*;
#(
  parameter int unsigned WORD_W = PROBE_WORD_W,
  parameter int unsigned SLOTS  = PROBE_SLOTS,
  localparam int unsigned CNT_W = $clog2(SLOTS)
) (
  input  logic              frame_on,
  input  logic [CNT_W-1:0]  slot,
  input  logic [WORD_W-1:0] shadow,
  output logic              data_o,
  output logic              mark_o
);

  logic payload_slot;

  always_comb begin
    payload_slot = slot_has_bit(32'(slot), WORD_W);
    data_o = frame_on && payload_slot && shadow[slot];
    mark_o = frame_on && (slot == '0);
  end

endmodule

// File: rtl/probe_serializer.sv
module probe_serializer
  import probe_ser_pkg::*;
#(
  parameter int unsigned WORD_W = PROBE_WORD_W,
  parameter int unsigned SLOTS  = PROBE_SLOTS,
  localparam int unsigned CNT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              one_shot,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_upd,
  output logic              probe_data,
  output logic              probe_mark
);

  // named internal events, observed by the bound checker
  logic              frame_on;
  logic [CNT_W-1:0]  slot;
  logic              frame_start;
  logic              pend;
  logic [WORD_W-1:0] shadow;
  probe_mode_e       mode;

  assign mode = one_shot ? MODE_SHOT : MODE_FREE;

  probe_frame_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bit_tick    (bit_tick),
    .mode        (mode),
    .word_upd    (word_upd),
    .frame_on    (frame_on),
    .slot        (slot),
    .frame_start (frame_start),
    .pend        (pend)
  );

  probe_word_latch #(.WORD_W(WORD_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (frame_start),
    .word_in (word_in),
    .shadow  (shadow)
  );

  probe_bit_select #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_sel (
    .frame_on (frame_on),
    .slot     (slot),
    .shadow   (shadow),
    .data_o   (probe_data),
    .mark_o   (probe_mark)
  );

endmodule

// File: rtl/probe_serializer_chk.sv
module probe_serializer_chk #(
  parameter int unsigned WORD_W = 30,
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned CNT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick,
  input logic              one_shot,
  input logic              word_upd,
  input logic              frame_on,
  input logic [CNT_W-1:0]  slot,
  input logic              frame_start,
  input logic              pend,
  input logic [WORD_W-1:0] shadow,
  input logic              probe_data,
  input logic              probe_mark
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> (!probe_data && !probe_mark && slot == '0)); // R1

  AST_FREE_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (!rst && !one_shot && frame_on && bit_tick) |=> frame_on); // R2

  AST_GAP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (32'(slot) >= WORD_W) |-> (!probe_data && !probe_mark)); // R4

  AST_MARK_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (!rst && probe_mark && bit_tick) |=> !probe_mark); // R5

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!rst && !bit_tick) |=> ($stable(slot) && $stable(probe_data) && $stable(probe_mark))); // R6

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!rst && frame_on && bit_tick && slot != LAST) |=> (slot == $past(slot) + 1'b1)); // R6

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!rst && !frame_start) |=> $stable(shadow)); // R7

  AST_SHOT_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!rst && one_shot && !frame_on && !pend && !word_upd) |=> !frame_on); // R8

endmodule

bind probe_serializer probe_serializer_chk #(.WORD_W(WORD_W), .SLOTS(SLOTS)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_tick    (bit_tick),
  .one_shot    (one_shot),
  .word_upd    (word_upd),
  .frame_on    (frame_on),
  .slot        (slot),
  .frame_start (frame_start),
  .pend        (pend),
  .shadow      (shadow),
  .probe_data  (probe_data),
  .probe_mark  (probe_mark)
);

// File: tb/test_probe_serializer.sv
`timescale 1ns/1ps
module test_probe_serializer;

  localparam int W = 30;
  localparam int S = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_tick = 1'b0;
  logic         one_shot = 1'b0;
  logic [W-1:0] word_in = '0;
  logic         word_upd = 1'b0;
  logic         probe_data;
  logic         probe_mark;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  probe_serializer i_probe_serializer (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .one_shot(one_shot),
    .word_in(word_in), .word_upd(word_upd),
    .probe_data(probe_data), .probe_mark(probe_mark)
  );

  function automatic logic [W-1:0] pattern(input int f);
    case (f % 5)
      0: return 30'h2AAAAAAA;
      1: return 30'h15555555;
      2: return 30'h3FFFFFFF;
      3: return 30'h00000001;
      default: return W'((f + 1) * 32'h9E3779B9);
    endcase
  endfunction

  function automatic logic exp_bit(input logic [W-1:0] w, input int s);
    if (s < W) return w[s];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic exp_d, input logic exp_m);
    checks++;
    if (probe_data !== exp_d || probe_mark !== exp_m) begin
      fails++;
      $display("FAIL %s: data/mark actual=%b%b expected=%b%b", req,
               probe_data, probe_mark, exp_d, exp_m);
    end
  endtask

  // one tick, then 'gap' idle cycles; returns at a negedge after the state settled
  task automatic tick(input int gap);
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) word_upd = 1'b1;
    @(negedge clk) word_upd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) chk("R1 reset", 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] cur;
    // ---------------- free-run ----------------
    one_shot = 1'b0;
    word_in  = pattern(0);
    do_reset();
    repeat (4) @(negedge clk);
    chk("R6 no tick before first frame", 1'b0, 1'b0);
    for (int f = 0; f < 5; f++) begin
      cur = pattern(f);
      for (int s = 0; s < S; s++) begin
        tick(s % 3);
        chk(s < W ? "R3 R5 payload slot" : "R4 gap slot", exp_bit(cur, s), s == 0);
        if (s == 7) word_in = ~cur;               // R7 mid-frame change
        if (f == 1 && s == 12) begin              // R6 hold with strobes
          for (int h = 0; h < 6; h++) begin
            @(negedge clk) word_upd = h[0];
            chk("R6 hold without tick", exp_bit(cur, s), 1'b0);
          end
          word_upd = 1'b0;
        end
        if (s == S - 1) word_in = pattern(f + 1); // R2 next frame follows directly
      end
    end

    // ---------------- single-shot ----------------
    one_shot = 1'b1;
    word_in  = pattern(4);
    do_reset();
    for (int i = 0; i < 40; i++) begin
      tick(i % 2);
      chk("R8 idle before strobe", 1'b0, 1'b0);
    end
    strobe();
    chk("R8 strobe alone does not start", 1'b0, 1'b0);
    cur = pattern(4);
    for (int s = 0; s < S; s++) begin
      tick(1);
      chk("R8 single frame", exp_bit(cur, s), s == 0);
    end
    for (int i = 0; i < 35; i++) begin
      tick(0);
      chk("R8 idle after frame", 1'b0, 1'b0);
    end

    // pending strobes (R9, R10)
    word_in = 30'h0F0F0F0F;
    strobe();
    cur = 30'h0F0F0F0F;
    for (int s = 0; s < S; s++) begin
      tick(s % 2);
      chk("R9 first frame", exp_bit(cur, s), s == 0);
      if (s == 10) begin word_in = 30'h12345678; strobe(); end
      if (s == 15) strobe();
      if (s == 20) word_in = 30'h3C3A5A69;
    end
    cur = 30'h3C3A5A69;
    for (int s = 0; s < S; s++) begin
      tick(1);
      chk("R9 pending frame uses word at start", exp_bit(cur, s), s == 0);
    end
    for (int i = 0; i < 34; i++) begin
      tick(0);
      chk("R10 strobes collapse to one frame", 1'b0, 1'b0);
    end

    // strobe and tick together, then reset mid-frame
    word_in = 30'h2F00FF0F;
    @(negedge clk) begin bit_tick = 1'b1; word_upd = 1'b1; end
    @(negedge clk) begin bit_tick = 1'b0; word_upd = 1'b0; end
    chk("R8 strobe with tick starts frame", 1'b1, 1'b1);
    for (int s = 1; s < 9; s++) begin
      tick(0);
      chk("R3 frame bits", exp_bit(30'h2F00FF0F, s), 1'b0);
    end
    do_reset();
    for (int i = 0; i < 36; i++) begin
      tick(0);
      chk("R1 idle after mid-frame reset", 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule